// File: doc/BRIEF.md
# Kogge-Stone Parallel Prefix Adder

This block adds two unsigned operands and a carry-in and returns the sum together with a carry-out. It does not ripple the carry from bit to bit. Each bit position first produces a generate term and a propagate term. A logarithmic prefix tree then merges these terms into group terms. At every level the distance between merged positions doubles. Each node in the tree is a separate instance of one small merge operator. The carry into every bit is read directly from the tree output, and the sum bits are derived from those carries.

The external carry-in behaves like the generate term of a virtual position just below bit 0, with a propagate term of zero. That virtual position is merged into bit 0 before the tree. As a result, every group that reaches bit 0 has a resolved carry, and the tree needs only log2(width) levels. With the default width of 8, that is three levels with spans 1, 2 and 4.

The adder is purely combinational. The carry-out placed above the sum gives the complete unsigned result, one bit wider than the operands.

Top module: `ks_prefix_adder`

## Requirements
- R1: For every combination of both operands and the carry-in, {cout_o, sum_o} equals the unsigned value a_i + b_i + cin_i, as a WIDTH+1 bit number.
- R2: The outputs depend only on the present inputs and hold no state: a change on the inputs shows on the outputs with no clock, and all-zero inputs give all-zero outputs.
- R3: When a_i ^ b_i is all ones, so that every position propagates, cout_o equals cin_i and every bit of sum_o equals the inverse of cin_i.
- R4: For the same operands, the result with cin_i = 1 is exactly one greater, modulo 2^(WIDTH+1), than the result with cin_i = 0.
- R5: cout_o is 1 exactly when a_i + b_i + cin_i is at least 2^WIDTH.
- R6: sum_o bit 0 equals a_i[0] ^ b_i[0] ^ cin_i; the carry into bit 0 is the external carry-in.
- R7: A carry generated at a low bit reaches every higher bit through a run of propagating positions. For example, 0x7F + 0x01 gives 0x80 with no carry-out, and 0x80 + 0x80 gives 0x00 with carry-out 1.
- R8: Swapping a_i and b_i leaves sum_o and cout_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First unsigned addend |
| b_i | input | WIDTH | Second unsigned addend |
| cin_i | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
The bench walks every operand pair with both carry-in values. A tree with a wrong span or a wrong source index at any level would therefore miss carries for some pairs. The bench also targets operand pairs whose propagate pattern is all ones, since only there does the carry-in have to cross all eight positions. It compares the two carry-in results for the same operands: an adder that drops or doubles the carry-in, or folds it in with the wrong propagate, fails that comparison. Swapped operands and long generate-then-propagate runs such as 0x7F + 0x01 catch a merge operator whose high and low inputs are reversed.

// File: rtl/ks_pkg.sv
package ks_pkg;

  // Group term: does the span create a carry, and does it pass one through.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Merge a more significant span (hi) with the span directly below it (lo).
  function automatic gp_t gp_combine(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Carry into position k, given group generates that each reach down to bit 0.
  function automatic logic carry_into(input int k, input logic cin, input logic grp_g_below);
    return (k == 0) ? cin : grp_g_below;
  endfunction

endpackage

// File: rtl/ks_gp_merge.sv
module ks_gp_merge
  import ks_pkg::*;
(
  input  gp_t hi_i,
  input  gp_t lo_i,
  output gp_t grp_o
);

  assign grp_o = gp_combine(hi_i, lo_i);

endmodule

// File: rtl/ks_bit_gp.sv
module ks_bit_gp #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o,
  output logic [WIDTH-1:0] half_o
);

  logic [WIDTH-1:0] bit_g;
  logic [WIDTH-1:0] bit_p;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_g[i]  = a_i[i] & b_i[i];
    assign bit_p[i]  = a_i[i] ^ b_i[i];
    assign half_o[i] = bit_p[i];
    if (i == 0) begin : g_fold
      // Virtual position below bit 0: generate = cin, propagate = 0.
      assign gen_o[i]  = bit_g[i] | (bit_p[i] & cin_i);
      assign prop_o[i] = 1'b0;
    end else begin : g_plain
      assign gen_o[i]  = bit_g[i];
      assign prop_o[i] = bit_p[i];
    end
  end

  // R6: the folded bit-0 generate is set only by a carry the LSB really sends up.
  always_comb begin
    if (!$isunknown({a_i[0], b_i[0], cin_i}))
      p_fold_lsb_r6: assert (gen_o[0] == ((a_i[0] + b_i[0] + cin_i) > 1));
  end

endmodule

// File: rtl/ks_prefix_net.sv
module ks_prefix_net
  import ks_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  output logic [WIDTH-1:0] grp_g_o
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [LEVELS:0][WIDTH-1:0] lvl_g;
  logic [LEVELS:0][WIDTH-1:0] lvl_p;

  assign lvl_g[0] = gen_i;
  assign lvl_p[0] = prop_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int SPAN = 1 << l;
    for (genvar i = 0; i < WIDTH; i++) begin : g_node
      if (i >= SPAN) begin : g_op
        gp_t hi, lo, res;
        assign hi = '{g: lvl_g[l][i],      p: lvl_p[l][i]};
        assign lo = '{g: lvl_g[l][i-SPAN], p: lvl_p[l][i-SPAN]};
        ks_gp_merge u_merge (
          .hi_i (hi),
          .lo_i (lo),
          .grp_o(res)
        );
        assign lvl_g[l+1][i] = res.g;
        assign lvl_p[l+1][i] = res.p;
      end else begin : g_pass
        assign lvl_g[l+1][i] = lvl_g[l][i];
        assign lvl_p[l+1][i] = lvl_p[l][i];
      end
    end
  end

  assign grp_g_o = lvl_g[LEVELS];

  // R1: after the last level every group reaches the virtual position, so none passes a carry through.
  always_comb begin
    if (!$isunknown(prop_i))
      p_groups_closed_r1: assert (lvl_p[LEVELS] == '0);
  end

endmodule

// File: rtl/ks_sum_stage.sv
module ks_sum_stage
  import ks_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] half_i,
  input  logic [WIDTH-1:0] grp_g_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] carry_in_bit;

  for (genvar k = 0; k < WIDTH; k++) begin : g_sum
    if (k == 0) begin : g_lsb
      assign carry_in_bit[k] = carry_into(k, cin_i, 1'b0);
    end else begin : g_upper
      assign carry_in_bit[k] = carry_into(k, cin_i, grp_g_i[k-1]);
    end
    assign sum_o[k] = half_i[k] ^ carry_in_bit[k];
  end

  assign cout_o = grp_g_i[WIDTH-1];

  // R3: with every position propagating, the carry-in alone decides the carry-out.
  always_comb begin
    if (!$isunknown({half_i, grp_g_i, cin_i}) && (&half_i))
      p_full_prop_r3: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}});
  end

endmodule

// File: rtl/ks_prefix_adder.sv
module ks_prefix_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] gen_w;
  logic [WIDTH-1:0] prop_w;
  logic [WIDTH-1:0] half_w;
  logic [WIDTH-1:0] grp_g_w;

  ks_bit_gp #(.WIDTH(WIDTH)) u_bit_gp (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .gen_o (gen_w),
    .prop_o(prop_w),
    .half_o(half_w)
  );

  ks_prefix_net #(.WIDTH(WIDTH)) u_prefix (
    .gen_i  (gen_w),
    .prop_i (prop_w),
    .grp_g_o(grp_g_w)
  );

  ks_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .half_i (half_w),
    .grp_g_i(grp_g_w),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

  // R1 and R5: the tree result matches a plain wide addition.
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      p_exact_sum_r1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i)));
      p_cout_range_r5: assert (cout_o == ((a_i + b_i + cin_i) >= (1 << WIDTH)));
    end
  end

endmodule

// File: tb/ks_prefix_adder_bench.sv
module ks_prefix_adder_bench;

  localparam int W = 8;
  localparam int NVEC = 12;

  // Each entry: {a[8], b[8], cin[1], expected {cout,sum}[9]}
  localparam logic [25:0] VECS [NVEC] = '{
    {8'h00, 8'h00, 1'b0, 9'h000},
    {8'hFF, 8'hFF, 1'b1, 9'h1FF},
    {8'hFF, 8'h00, 1'b1, 9'h100},
    {8'hFF, 8'h01, 1'b0, 9'h100},
    {8'h7F, 8'h01, 1'b0, 9'h080},
    {8'h80, 8'h80, 1'b0, 9'h100},
    {8'h55, 8'hAA, 1'b0, 9'h0FF},
    {8'h55, 8'hAA, 1'b1, 9'h100},
    {8'h0F, 8'hF0, 1'b1, 9'h100},
    {8'h12, 8'h34, 1'b1, 9'h047},
    {8'hFE, 8'h01, 1'b0, 9'h0FF},
    {8'hC3, 8'h3D, 1'b0, 9'h100}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b;
  logic cin;
  logic [W-1:0] sum;
  logic cout;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ks_prefix_adder #(.WIDTH(W)) u_ks_prefix_adder (
    .a_i   (a),
    .b_i   (b),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    int t;
    t = int'(x) + int'(y) + int'(c);
    return t[W:0];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s a=%02h b=%02h cin=%0d actual=%0h expected=%0h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      report();
    end
  end

  initial begin
    logic [W:0] r0, r1, rs;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: all-zero inputs during reset give all-zero outputs
    chk("R2 zero in reset", int'({cout, sum}), 0);
    rst = 1'b0;

    // Table walk (R1, R7)
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v][25:18], VECS[v][17:10], VECS[v][9]);
      chk("R1 R7 table", int'({cout, sum}), int'(VECS[v][8:0]));
    end

    // R2: output follows a new input within the same cycle, no clock dependence
    apply(8'h01, 8'h02, 1'b0);
    #1 a = 8'h10;
    #0.5 chk("R2 no clock", int'({cout, sum}), 9'h012);

    // R3: full propagate patterns
    for (int x = 0; x < 256; x += 17) begin
      for (int c = 0; c < 2; c++) begin
        apply(W'(x), ~W'(x), c[0]);
        chk("R3 full propagate", int'({cout, sum}), int'({c[0], {W{~c[0]}}}));
      end
    end

    // R7 directed long runs
    apply(8'h01, 8'h7F, 1'b0);
    chk("R7 run up", int'({cout, sum}), 9'h080);
    apply(8'h00, 8'h00, 1'b1);
    chk("R6 cin only", int'({cout, sum}), 9'h001);

    // Random phase: R4, R8, R1
    for (int n = 0; n < 50; n++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      apply(x, y, 1'b0);
      r0 = {cout, sum};
      apply(x, y, 1'b1);
      r1 = {cout, sum};
      chk("R4 cin adds one", int'(r1), int'((r0 + 9'd1)));
      chk("R1 random", int'(r1), int'(ref_add(x, y, 1'b1)));
      apply(y, x, 1'b1);
      rs = {cout, sum};
      chk("R8 swap", int'(rs), int'(r1));
    end

    // Exhaustive sweep: R1, R5, R6
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          apply(W'(x), W'(y), c[0]);
          chk("R1 exhaustive", int'({cout, sum}), int'(ref_add(W'(x), W'(y), c[0])));
          if ((x + y + c) >= 256) begin
            if (cout !== 1'b1) chk("R5 cout high", int'(cout), 1);
          end else begin
            if (cout !== 1'b0) chk("R5 cout low", int'(cout), 0);
          end
          if (sum[0] !== (x[0] ^ y[0] ^ c[0]))
            chk("R6 lsb", int'(sum[0]), int'(x[0] ^ y[0] ^ c[0]));
        end
      end
    end
    chk("R5 final case", int'(cout), 1);
    chk("R6 final case", int'(sum[0]), 1);

    done = 1'b1;
    report();
  end

endmodule